// File: doc/BRIEF.md
# Speculative Epoch Version Cache

This block is a small, fully associative data store that holds memory lines for several speculative epochs running at the same time, and it catches read-after-write ordering violations between them. The epochs have a fixed logical age, oldest first. Every line carries a valid bit, one speculatively-modified flag per epoch and one speculatively-loaded flag per epoch. A line whose modified flags are all clear is the committed copy of its address. A line with exactly one modified flag set is the private version of that epoch.

A requester presents one operation per cycle: a load, a store, a commit of the oldest epoch, or a squash of one epoch. Each operation carries an epoch id. A load returns the youngest version that is not younger than the requester, and a result pulse follows one cycle later. A store that lands under a younger epoch's earlier read raises a one-cycle violation pulse for that epoch and for every epoch younger still. Stores never merge two epochs' changes into one line. If an operation needs a new line and none is free, it is held back by `busy` until a commit frees one. A miss is filled with zero data.

Top module: `spec_version_cache`

## Requirements
- R1: After reset no line is valid, `head_epoch` is 0, and `rsp_valid`, `violation` and `busy` are low.
- R2: A load (`req_op`=0) accepted in cycle t drives `rsp_valid` high in cycle t+1. `rsp_data` is the data of the version owned by the epoch of highest logical rank that is not above the requester's rank. With no such version it is the committed copy. With neither it is zero. The rank of an epoch is (id − `head_epoch`) mod EPOCHS, and rank 0 is the oldest.
- R3: A load marks the requester as a reader of the line it returned. A later store (`req_op`=1) to that address by an epoch of lower rank raises the reader's bit in `violation` in the cycle after the store.
- R4: Whenever any epoch is flagged, every epoch of higher rank than the lowest-ranked flagged epoch is flagged in the same pulse.
- R5: A store by an epoch that has no version of the address writes a fresh line owned by that epoch. Other epochs' versions and the committed copy keep their data. A repeated store by the same epoch overwrites its own version.
- R6: A commit (`req_op`=2) turns every version of the epoch at `head_epoch` into the committed copy. It discards the older committed copy of the same address, keeps that copy's reader marks, clears the committing epoch's reader marks, and advances `head_epoch` by one modulo EPOCHS. No other operation changes `head_epoch`.
- R7: A squash (`req_op`=3) of an epoch removes all of its versions and its reader marks. Its later loads see only older versions or the committed copy.
- R8: `busy` is high only while a load or store is presented that needs a new line when every line is valid. While `busy` is high the request has no effect on data, reader marks, `violation`, `rsp_valid` or `head_epoch`.
- R9: The epoch at `head_epoch` is never flagged in `violation`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation presented this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 commit oldest, 3 squash |
| req_epoch | input | $clog2(EPOCHS) | Epoch id of the load, store or squash |
| req_addr | input | AW | Line address of a load or store |
| req_wdata | input | DW | Store data |
| busy | output | 1 | Request cannot be taken for lack of a free line |
| rsp_valid | output | 1 | Load result valid, one cycle after acceptance |
| rsp_data | output | DW | Load result data |
| violation | output | EPOCHS | One-cycle pulse per epoch that must restart |
| head_epoch | output | $clog2(EPOCHS) | Id of the current oldest epoch |

## Verification
The bench builds the block with EPOCHS=4, LINES=8, AW=8 and DW=16. Four epochs let a single commit move the oldest position, so the rank wrap-around is exercised: epoch 0 becomes the youngest and must read a version written by epoch 3. Eight lines can be filled in a handful of operations, which brings both the stalled store and the stalled load within reach, as well as their release by a commit that drops a superseded committed copy.

// File: rtl/svc_pkg.sv
package svc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_COMMIT = 2'd2,
        OP_SQUASH = 2'd3
    } svc_op_e;

    // Logical age of an epoch relative to the current oldest one (0 = oldest).
    function automatic int unsigned age_rank(int unsigned id, int unsigned head,
                                             int unsigned n);
        return (id + n - head) % n;
    endfunction

endpackage

// File: rtl/svc_free_pick.sv
module svc_free_pick #(
    parameter int LINES = 8,
    parameter int IDX_W = 3
) (
    input  logic [LINES-1:0] ln_valid,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Lowest-numbered free line wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (!ln_valid[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/svc_match.sv
module svc_match
    import svc_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int EPOCHS = 4,
    parameter int AW     = 8,
    parameter int IDX_W  = 3,
    parameter int EW     = 2
) (
    input  logic [LINES-1:0]  ln_valid,
    input  logic [AW-1:0]     ln_addr [LINES],
    input  logic [EPOCHS-1:0] ln_sm   [LINES],
    input  logic [EPOCHS-1:0] ln_sl   [LINES],
    input  logic [AW-1:0]     addr,
    input  logic [EW-1:0]     epoch,
    input  logic [EW-1:0]     head,
    output logic              comm_hit,
    output logic [IDX_W-1:0]  comm_idx,
    output logic              ver_hit,
    output logic [IDX_W-1:0]  ver_idx,
    output logic              own_hit,
    output logic [IDX_W-1:0]  own_idx,
    output logic [EPOCHS-1:0] late_sl
);
    int unsigned req_r;
    int unsigned best_r;
    int unsigned owner_r;

    always_comb begin
        comm_hit = 1'b0;
        comm_idx = '0;
        ver_hit  = 1'b0;
        ver_idx  = '0;
        own_hit  = 1'b0;
        own_idx  = '0;
        late_sl  = '0;
        best_r   = 0;
        owner_r  = 0;
        req_r    = age_rank(int'(epoch), int'(head), EPOCHS);
        for (int i = 0; i < LINES; i++) begin
            if (ln_valid[i] && ln_addr[i] == addr) begin
                if (ln_sm[i] == '0) begin
                    comm_hit = 1'b1;
                    comm_idx = IDX_W'(i);
                end else begin
                    if (ln_sm[i][epoch]) begin
                        own_hit = 1'b1;
                        own_idx = IDX_W'(i);
                    end
                    for (int k = 0; k < EPOCHS; k++) begin
                        if (ln_sm[i][k]) owner_r = age_rank(k, int'(head), EPOCHS);
                    end
                    if (owner_r <= req_r && (!ver_hit || owner_r > best_r)) begin
                        ver_hit = 1'b1;
                        ver_idx = IDX_W'(i);
                        best_r  = owner_r;
                    end
                end
                for (int k = 0; k < EPOCHS; k++) begin
                    if (ln_sl[i][k] && age_rank(k, int'(head), EPOCHS) > req_r)
                        late_sl[k] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spec_version_cache.sv
module spec_version_cache
    import svc_pkg::*;
#(
    parameter  int EPOCHS = 4,
    parameter  int LINES  = 8,
    parameter  int AW     = 8,
    parameter  int DW     = 16,
    localparam int EW     = $clog2(EPOCHS),
    localparam int IDX_W  = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [EW-1:0]     req_epoch,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_data,
    output logic [EPOCHS-1:0] violation,
    output logic [EW-1:0]     head_epoch
);
    logic [LINES-1:0]  ln_valid;
    logic [AW-1:0]     ln_addr [LINES];
    logic [DW-1:0]     ln_data [LINES];
    logic [EPOCHS-1:0] ln_sm   [LINES];
    logic [EPOCHS-1:0] ln_sl   [LINES];

    svc_op_e           op;
    logic              comm_hit, ver_hit, own_hit, free_found;
    logic [IDX_W-1:0]  comm_idx, ver_idx, own_idx, free_idx;
    logic [EPOCHS-1:0] late_sl, viol_mask, ep_bit, head_bit;
    logic [LINES-1:0]  drop_line;
    logic [EPOCHS-1:0] merge_sl [LINES];
    logic              need_line, accept;

    assign op       = svc_op_e'(req_op);
    assign ep_bit   = EPOCHS'(1) << req_epoch;
    assign head_bit = EPOCHS'(1) << head_epoch;

    svc_match #(
        .LINES(LINES), .EPOCHS(EPOCHS), .AW(AW), .IDX_W(IDX_W), .EW(EW)
    ) match_i (
        .ln_valid(ln_valid), .ln_addr(ln_addr), .ln_sm(ln_sm), .ln_sl(ln_sl),
        .addr(req_addr), .epoch(req_epoch), .head(head_epoch),
        .comm_hit(comm_hit), .comm_idx(comm_idx),
        .ver_hit(ver_hit), .ver_idx(ver_idx),
        .own_hit(own_hit), .own_idx(own_idx),
        .late_sl(late_sl)
    );

    svc_free_pick #(.LINES(LINES), .IDX_W(IDX_W)) free_i (
        .ln_valid(ln_valid), .found(free_found), .idx(free_idx)
    );

    // A flagged reader drags every younger epoch along with it.
    always_comb begin
        viol_mask = '0;
        for (int j = 0; j < EPOCHS; j++) begin
            for (int k = 0; k < EPOCHS; k++) begin
                if (late_sl[k] && age_rank(k, int'(head_epoch), EPOCHS)
                                  <= age_rank(j, int'(head_epoch), EPOCHS))
                    viol_mask[j] = 1'b1;
            end
        end
    end

    // Committed copies superseded by the committing epoch's versions.
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            drop_line[i] = 1'b0;
            merge_sl[i]  = '0;
        end
        for (int i = 0; i < LINES; i++) begin
            for (int j = 0; j < LINES; j++) begin
                if (ln_valid[i] && ln_valid[j] && ln_sm[i] == '0 &&
                    ln_sm[j][head_epoch] && ln_addr[i] == ln_addr[j]) begin
                    drop_line[i] = 1'b1;
                    merge_sl[j]  = merge_sl[j] | ln_sl[i];
                end
            end
        end
    end

    always_comb begin
        unique case (op)
            OP_LOAD:  need_line = !ver_hit && !comm_hit;
            OP_STORE: need_line = !own_hit;
            default:  need_line = 1'b0;
        endcase
    end

    assign busy   = req_valid && need_line && !free_found;
    assign accept = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ln_valid   <= '0;
            head_epoch <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            violation  <= '0;
            for (int i = 0; i < LINES; i++) begin
                ln_addr[i] <= '0;
                ln_data[i] <= '0;
                ln_sm[i]   <= '0;
                ln_sl[i]   <= '0;
            end
        end else begin
            rsp_valid <= 1'b0;
            violation <= '0;
            if (accept) begin
                unique case (op)
                    OP_LOAD: begin
                        rsp_valid <= 1'b1;
                        if (ver_hit) begin
                            rsp_data         <= ln_data[ver_idx];
                            ln_sl[ver_idx]   <= ln_sl[ver_idx] | ep_bit;
                        end else if (comm_hit) begin
                            rsp_data         <= ln_data[comm_idx];
                            ln_sl[comm_idx]  <= ln_sl[comm_idx] | ep_bit;
                        end else begin
                            rsp_data           <= '0;
                            ln_valid[free_idx] <= 1'b1;
                            ln_addr[free_idx]  <= req_addr;
                            ln_data[free_idx]  <= '0;
                            ln_sm[free_idx]    <= '0;
                            ln_sl[free_idx]    <= ep_bit;
                        end
                    end
                    OP_STORE: begin
                        violation <= viol_mask;
                        if (own_hit) begin
                            ln_data[own_idx] <= req_wdata;
                        end else begin
                            ln_valid[free_idx] <= 1'b1;
                            ln_addr[free_idx]  <= req_addr;
                            ln_data[free_idx]  <= req_wdata;
                            ln_sm[free_idx]    <= ep_bit;
                            ln_sl[free_idx]    <= '0;
                        end
                    end
                    OP_COMMIT: begin
                        for (int i = 0; i < LINES; i++) begin
                            if (ln_valid[i] && ln_sm[i][head_epoch]) begin
                                ln_sm[i] <= '0;
                                ln_sl[i] <= (ln_sl[i] | merge_sl[i]) & ~head_bit;
                            end else if (drop_line[i]) begin
                                ln_valid[i] <= 1'b0;
                                ln_sl[i]    <= '0;
                            end else begin
                                ln_sl[i]    <= ln_sl[i] & ~head_bit;
                            end
                        end
                        head_epoch <= head_epoch + 1'b1;
                    end
                    OP_SQUASH: begin
                        for (int i = 0; i < LINES; i++) begin
                            if (ln_sm[i][req_epoch]) begin
                                ln_valid[i] <= 1'b0;
                                ln_sm[i]    <= '0;
                                ln_sl[i]    <= '0;
                            end else begin
                                ln_sl[i]    <= ln_sl[i] & ~ep_bit;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/svc_chk.sv
module svc_chk #(
    parameter  int EPOCHS = 4,
    localparam int EW     = $clog2(EPOCHS)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic              busy,
    input logic              rsp_valid,
    input logic [EPOCHS-1:0] violation,
    input logic [EW-1:0]     head_epoch
);
    logic [EW-1:0] youngest;
    assign youngest = head_epoch - 1'b1;

    // R8
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (req_valid && (req_op == 2'd0 || req_op == 2'd1)));

    // R2
    rsp_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !busy && req_op == 2'd0));

    // R9
    oldest_safe_chk: assert property (@(posedge clk) disable iff (rst)
        !violation[head_epoch]);

    // R4
    youngest_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (|violation) |-> violation[youngest]);

    // R6
    head_step_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_op == 2'd2) |=> head_epoch == EW'($past(head_epoch) + 1'b1));

    // R6
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_op == 2'd2) |=> $stable(head_epoch));
endmodule

bind spec_version_cache svc_chk #(.EPOCHS(EPOCHS)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .busy(busy),
    .rsp_valid(rsp_valid), .violation(violation), .head_epoch(head_epoch)
);

// File: tb/spec_version_cache_tb_top.sv
`timescale 1ns/1ps
module spec_version_cache_tb_top;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  ep;
        logic [7:0]  addr;
        logic [15:0] wd;
        logic        rsp;
        logic [15:0] data;
        logic [3:0]  viol;
        logic [1:0]  head;
    } vec_t;

    // op: 0 load, 1 store, 2 commit, 3 squash
    localparam vec_t VEC [16] = '{
        '{2'd0, 2'd2, 8'h10, 16'h0000, 1'b1, 16'h0000, 4'b0000, 2'd0}, // R2 miss fills zero
        '{2'd1, 2'd0, 8'h10, 16'h1111, 1'b0, 16'h0000, 4'b1100, 2'd0}, // R3 R4 e2 read early
        '{2'd0, 2'd1, 8'h10, 16'h0000, 1'b1, 16'h1111, 4'b0000, 2'd0}, // R2 forward from e0
        '{2'd1, 2'd3, 8'h10, 16'h3333, 1'b0, 16'h0000, 4'b0000, 2'd0}, // R5 replica for e3
        '{2'd0, 2'd2, 8'h10, 16'h0000, 1'b1, 16'h1111, 4'b0000, 2'd0}, // R2 younger version hidden
        '{2'd0, 2'd3, 8'h10, 16'h0000, 1'b1, 16'h3333, 4'b0000, 2'd0}, // R2 own version
        '{2'd1, 2'd1, 8'h10, 16'h2222, 1'b0, 16'h0000, 4'b1100, 2'd0}, // R3 R5
        '{2'd0, 2'd2, 8'h10, 16'h0000, 1'b1, 16'h2222, 4'b0000, 2'd0}, // R2 nearest older
        '{2'd0, 2'd0, 8'h20, 16'h0000, 1'b1, 16'h0000, 4'b0000, 2'd0}, // R2 zero fill
        '{2'd2, 2'd0, 8'h00, 16'h0000, 1'b0, 16'h0000, 4'b0000, 2'd1}, // R6 commit e0
        '{2'd0, 2'd0, 8'h10, 16'h0000, 1'b1, 16'h3333, 4'b0000, 2'd1}, // R6 e0 now youngest
        '{2'd3, 2'd3, 8'h00, 16'h0000, 1'b0, 16'h0000, 4'b0000, 2'd1}, // R7 squash e3
        '{2'd0, 2'd0, 8'h10, 16'h0000, 1'b1, 16'h2222, 4'b0000, 2'd1}, // R7 e3 version gone
        '{2'd1, 2'd2, 8'h10, 16'h5555, 1'b0, 16'h0000, 4'b0001, 2'd1}, // R3 R9 only e0 flagged
        '{2'd0, 2'd1, 8'h10, 16'h0000, 1'b1, 16'h2222, 4'b0000, 2'd1}, // R5 e1 version intact
        '{2'd0, 2'd2, 8'h10, 16'h0000, 1'b1, 16'h5555, 4'b0000, 2'd1}  // R5 e2 own version
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_epoch = 2'd0;
    logic [7:0]  req_addr = 8'h00;
    logic [15:0] req_wdata = 16'h0000;
    logic        busy, rsp_valid;
    logic [15:0] rsp_data;
    logic [3:0]  violation;
    logic [1:0]  head_epoch;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic        got_busy, got_rsp;
    logic [15:0] got_data;
    logic [3:0]  got_viol;
    logic [1:0]  got_head;

    always #2.5 clk = ~clk;

    spec_version_cache #(.EPOCHS(4), .LINES(8), .AW(8), .DW(16)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_epoch(req_epoch), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .violation(violation), .head_epoch(head_epoch)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [1:0] ep,
                          input logic [7:0] a, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_epoch = ep;
        req_addr  = a;
        req_wdata = wd;
        #1 got_busy = busy;
        @(negedge clk);
        req_valid = 1'b0;
        got_rsp  = rsp_valid;
        got_data = rsp_data;
        got_viol = violation;
        got_head = head_epoch;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(violation == 4'b0, "R1 violation", violation, 0);
        chk(head_epoch == 2'd0, "R1 head_epoch", head_epoch, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);

        for (int v = 0; v < 16; v++) begin
            run_op(VEC[v].op, VEC[v].ep, VEC[v].addr, VEC[v].wd);
            chk(got_busy == 1'b0, $sformatf("R8 busy vec%0d", v), got_busy, 0);
            chk(got_rsp == VEC[v].rsp, $sformatf("R2 rsp_valid vec%0d", v), got_rsp, VEC[v].rsp);
            if (VEC[v].rsp)
                chk(got_data == VEC[v].data, $sformatf("R2 rsp_data vec%0d", v), got_data, VEC[v].data);
            chk(got_viol == VEC[v].viol, $sformatf("R3 R4 violation vec%0d", v), got_viol, VEC[v].viol);
            chk(got_head == VEC[v].head, $sformatf("R6 head vec%0d", v), got_head, VEC[v].head);
        end

        // R1 reset mid-run clears every line
        do_reset();
        chk(head_epoch == 2'd0, "R1 head after reset", head_epoch, 0);
        run_op(2'd0, 2'd0, 8'h10, 16'h0);
        chk(got_data == 16'h0 && got_rsp, "R1 lines cleared", got_data, 0);

        // R8 fill the store, then stall
        do_reset();
        run_op(2'd0, 2'd1, 8'h00, 16'h0);
        run_op(2'd1, 2'd0, 8'h00, 16'h0100);
        chk(got_viol == 4'b1110, "R4 flags e1 and younger", got_viol, 4'b1110);
        for (int a = 1; a < 7; a++) run_op(2'd1, 2'd0, 8'(a), 16'h0100 + 16'(a));
        run_op(2'd1, 2'd0, 8'h07, 16'hDEAD);
        chk(got_busy == 1'b1, "R8 store stalls when full", got_busy, 1);
        chk(got_viol == 4'b0 && !got_rsp, "R8 stalled store no effect", got_viol, 0);
        chk(got_head == 2'd0, "R8 head unchanged", got_head, 0);
        run_op(2'd2, 2'd0, 8'h00, 16'h0);
        chk(got_head == 2'd1, "R6 commit advances head", got_head, 1);
        run_op(2'd1, 2'd0, 8'h07, 16'h0107);
        chk(got_busy == 1'b0, "R6 commit frees superseded copy", got_busy, 0);
        run_op(2'd0, 2'd1, 8'h07, 16'h0);
        chk(got_busy == 1'b1, "R8 load stalls when full", got_busy, 1);
        chk(got_rsp == 1'b0, "R8 stalled load no response", got_rsp, 0);
        run_op(2'd0, 2'd0, 8'h07, 16'h0);
        chk(got_rsp && got_data == 16'h0107, "R5 own version data", got_data, 16'h0107);
        run_op(2'd0, 2'd1, 8'h03, 16'h0);
        chk(got_rsp && got_data == 16'h0103, "R6 committed data", got_data, 16'h0103);
        run_op(2'd0, 2'd1, 8'h00, 16'h0);
        chk(got_rsp && got_data == 16'h0100, "R6 committed replaces old copy", got_data, 16'h0100);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule